// File: doc/BRIEF.md
# Per-Frame Ancillary Packet Buffer

This block sits in a video stream path. It keeps the non-image packets that arrive ahead of each image frame, so that they can be sent out again together with that frame. The input is a valid/ready stream of symbols. Each transfer beat is one symbol, however many colour channels it carries. Start and end markers frame each packet. The low four bits of the first symbol of a packet give its type.

Storage is a ring of slots, and each slot holds one packet up to a fixed symbol limit. Packets that arrive since the last commit are pending. A one-cycle commit pulse binds every pending packet to the current frame and queues it for replay, oldest first. A one-cycle drop pulse discards the next image packet but leaves the pending packets where they are, so they join the following frame. Image packets are never stored. They pass straight through once every committed packet has left the output.

Packets longer than the limit are cut short. A frame that collects too many packets loses its oldest pending ones. Two saturating counters report how many packets were evicted and how many were truncated.

Top module: `anc_pkt_buffer`

## Requirements
- R1: After reset, `out_valid` is low and both status counters read zero. `out_valid` stays low until a commit binds at least one stored packet, or until an image packet is passing through.
- R2: Stored packets are not output before a commit. After a commit they are replayed in arrival order, with `out_sop` on the first symbol and `out_eop` on the last stored symbol of each packet.
- R3: A stored packet keeps at most MAX_LEN symbols, counting the header. Further symbols are accepted with `in_ready` high and are discarded, and `out_eop` marks the last kept symbol.
- R4: `trunc_count` rises by one for each packet that exceeded MAX_LEN symbols.
- R5: When a storable header arrives while MAX_PKTS packets are already pending, the oldest pending packet is discarded, never replayed, and `evict_count` rises by one.
- R6: A `frame_drop` pulse makes the next image packet be accepted without appearing at the output. Pending packets survive, and they count toward the limit of the next frame.
- R7: Control packets (type 4'hF) are consumed without being stored while `ctrl_keep` is 0. While `ctrl_keep` is 1 they are stored and replayed like any other type.
- R8: An image packet (type 4'h0) is output unmodified and untruncated. Its header is held off (`in_ready` low) while committed packets remain to be replayed.
- R9: The header of a storable packet is held off while all NUM_SLOTS slots are occupied by committed and pending packets. It is accepted once a replay frees a slot.
- R10: `evict_count` and `trunc_count` stop at their all-ones value and never wrap.
- R11: While a replayed symbol is presented and `out_ready` is low, `out_valid` stays high and the symbol and its markers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Input symbol accepted when high with `in_valid` |
| in_data | input | SYM_W | Input symbol; low 4 bits of a header give the type |
| in_sop | input | 1 | First symbol of a packet |
| in_eop | input | 1 | Last symbol of a packet |
| ctrl_keep | input | 1 | 1: store control packets, 0: consume them |
| frame_commit | input | 1 | Pulse binding pending packets to the current frame |
| frame_drop | input | 1 | Pulse discarding the next image packet, keeping pending packets |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Downstream accepts the output symbol |
| out_data | output | SYM_W | Output symbol |
| out_sop | output | 1 | First symbol of an output packet |
| out_eop | output | 1 | Last symbol of an output packet |
| evict_count | output | CNT_W | Saturating count of evicted packets |
| trunc_count | output | CNT_W | Saturating count of truncated packets |

## Verification
The bench targets these cases:

- **Truncation.** A packet three symbols past the limit must keep exactly MAX_LEN symbols, with the end marker moved onto the last one. A design that stalled on the extra symbols, or dropped the end marker, would either hang the sender or merge the packet with the next one.
- **Eviction.** With one packet too many, the oldest pending packet must vanish and the newest must survive. A design that evicted the wrong slot would replay a stale packet.
- **Carry-over after a drop.** Pending packets must survive the drop and take part in the next frame's limit. A design that ignored the carry would keep all of them, and one that freed them at the drop would lose them.
- **Full ring.** With every slot occupied, a new header must wait and then claim the slot that a replay frees. Getting this wrong overwrites a packet that has not yet been replayed.
- **Control handling and saturation.** Control packets must be stored only while `ctrl_keep` is 1, and the status counters must stop at all ones rather than wrap.

// File: rtl/anc_pkg.sv
`timescale 1ns/1ps
// Shared types and code values for the ancillary packet buffer.
// Assumes the packet type sits in the low TYPE_W bits of the header symbol.
package anc_pkg;
    localparam int TYPE_W = 4;
    localparam logic [TYPE_W-1:0] TYPE_IMAGE = 4'h0;
    localparam logic [TYPE_W-1:0] TYPE_CTRL  = 4'hF;

    // Handling class of the packet currently on the input.
    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,  // between packets
        K_STORE = 2'd1,  // written into a slot
        K_SINK  = 2'd2,  // consumed and dropped
        K_PASS  = 2'd3   // image, routed to the output
    } kind_t;
endpackage

// File: rtl/anc_sat_counter.sv
`timescale 1ns/1ps
// Saturating event counter: adds one per inc pulse and holds at all ones.
// Assumes at most one event per cycle.
module anc_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count up on each event unless already at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (inc && (count != '1))  count <= count + W'(1);
    end
endmodule

// File: rtl/anc_intake.sv
`timescale 1ns/1ps
// Input side: classifies each packet from its header, applies flow control,
// produces slot writes for storable packets and flags truncation.
// Assumes every packet starts with in_sop; a stray beat outside a packet is sunk.
module anc_intake import anc_pkg::*; #(
    parameter  int SYM_W     = 8,
    parameter  int NUM_SLOTS = 8,
    parameter  int MAX_LEN   = 12,
    localparam int SLOT_AW   = $clog2(NUM_SLOTS),
    localparam int IDX_W     = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [SYM_W-1:0]   in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    output logic               in_ready,
    input  logic               ctrl_keep,
    input  logic               slot_avail,
    input  logic               replay_busy,
    input  logic               drop_img,
    input  logic               out_ready,
    output logic               wr_en,
    output logic [SLOT_AW-1:0] wr_slot,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [SYM_W-1:0]   wr_data,
    output logic               hdr_store,
    output logic               pkt_done,
    output logic               trunc_hit,
    output logic               pass_route,
    output logic               img_done
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(MAX_LEN);

    kind_t            state, hdr_kind, cur_kind;
    logic [IDX_W-1:0] idx, pos;
    logic             trunc_seen, idle, acc, sink_ok;

    // Decode how the packet that starts on this beat is handled.
    always_comb begin
        if (!in_sop)                                       hdr_kind = K_SINK;
        else if (in_data[TYPE_W-1:0] == TYPE_IMAGE)         hdr_kind = K_PASS;
        else if (in_data[TYPE_W-1:0] == TYPE_CTRL && !ctrl_keep) hdr_kind = K_SINK;
        else                                               hdr_kind = K_STORE;
    end

    // Flow control and per-beat strobes for the current beat.
    always_comb begin
        idle     = (state == K_IDLE);
        cur_kind = idle ? hdr_kind : state;
        pos      = idle ? '0 : idx;
        sink_ok  = drop_img || out_ready;
        unique case (cur_kind)
            K_STORE: in_ready = idle ? slot_avail : 1'b1;
            K_PASS:  in_ready = idle ? (!replay_busy && sink_ok) : sink_ok;
            default: in_ready = 1'b1;
        endcase
        acc        = in_valid && in_ready;
        wr_en      = acc && (cur_kind == K_STORE) && (pos < LIMIT);
        wr_idx     = pos;
        wr_data    = in_data;
        hdr_store  = acc && idle && (cur_kind == K_STORE);
        pkt_done   = acc && (cur_kind == K_STORE) && in_eop;
        trunc_hit  = acc && (cur_kind == K_STORE) && (pos == LIMIT) && !trunc_seen;
        pass_route = (cur_kind == K_PASS) && (!idle || (in_valid && !replay_busy));
        img_done   = acc && (cur_kind == K_PASS) && in_eop;
    end

    // Packet state, saturating symbol index and truncation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= K_IDLE;
            idx        <= '0;
            trunc_seen <= 1'b0;
        end else if (acc) begin
            state      <= in_eop ? K_IDLE : cur_kind;
            idx        <= (pos < LIMIT) ? pos + IDX_W'(1) : pos;
            trunc_seen <= trunc_hit || (!idle && trunc_seen);
        end
    end

    // Write slot pointer moves on once a stored packet is complete.
    always_ff @(posedge clk) begin
        if (!rst_n)        wr_slot <= '0;
        else if (pkt_done) wr_slot <= (wr_slot == SLOT_AW'(NUM_SLOTS - 1)) ? '0 : wr_slot + SLOT_AW'(1);
    end
endmodule

// File: rtl/anc_slot_store.sv
`timescale 1ns/1ps
// Slot storage: NUM_SLOTS slots of MAX_LEN symbols plus a stored-length
// register per slot. A length of zero marks an evicted (dead) slot.
// Assumes write and kill never address the same slot in one cycle.
module anc_slot_store #(
    parameter  int SYM_W     = 8,
    parameter  int NUM_SLOTS = 8,
    parameter  int MAX_LEN   = 12,
    localparam int SLOT_AW   = $clog2(NUM_SLOTS),
    localparam int IDX_W     = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLOT_AW-1:0] wr_slot,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [SYM_W-1:0]   wr_data,
    input  logic               kill_en,
    input  logic [SLOT_AW-1:0] kill_slot,
    input  logic [SLOT_AW-1:0] rd_slot,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [SYM_W-1:0]   rd_data,
    output logic [IDX_W-1:0]   rd_len
);
    logic [SYM_W-1:0] mem [NUM_SLOTS][MAX_LEN];
    logic [IDX_W-1:0] len [NUM_SLOTS];

    // Symbol array write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_slot][wr_idx] <= wr_data;
    end

    // Per-slot stored length: grows with writes, zeroed on eviction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) len[i] <= '0;
        end else begin
            if (wr_en)   len[wr_slot]   <= wr_idx + IDX_W'(1);
            if (kill_en) len[kill_slot] <= '0;
        end
    end

    // Combinational read port for the replay side.
    always_comb begin
        rd_data = mem[rd_slot][rd_idx];
        rd_len  = len[rd_slot];
    end
endmodule

// File: rtl/anc_replay.sv
`timescale 1ns/1ps
// Replay side: walks committed slots oldest first, emits each stored packet
// with start/end markers and frees the slot after its last symbol. Dead slots
// are freed in one cycle without output.
// Assumes active is high only while committed slots remain.
module anc_replay #(
    parameter  int SYM_W     = 8,
    parameter  int NUM_SLOTS = 8,
    parameter  int MAX_LEN   = 12,
    localparam int SLOT_AW   = $clog2(NUM_SLOTS),
    localparam int IDX_W     = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [IDX_W-1:0]   rd_len,
    input  logic [SYM_W-1:0]   rd_data,
    input  logic               rep_ready,
    output logic [SLOT_AW-1:0] rd_slot,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               rep_valid,
    output logic [SYM_W-1:0]   rep_data,
    output logic               rep_sop,
    output logic               rep_eop,
    output logic               slot_free
);
    logic dead;

    // Present the current symbol and decide when the slot is retired.
    always_comb begin
        dead      = (rd_len == '0);
        rep_valid = active && !dead;
        rep_data  = rd_data;
        rep_sop   = (rd_idx == '0);
        rep_eop   = (rd_idx == rd_len - IDX_W'(1));
        slot_free = active && (dead || (rep_valid && rep_ready && rep_eop));
    end

    // Advance through symbols and slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_slot <= '0;
            rd_idx  <= '0;
        end else if (slot_free) begin
            rd_slot <= (rd_slot == SLOT_AW'(NUM_SLOTS - 1)) ? '0 : rd_slot + SLOT_AW'(1);
            rd_idx  <= '0;
        end else if (rep_valid && rep_ready) begin
            rd_idx  <= rd_idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/anc_pkt_buffer.sv
`timescale 1ns/1ps
// Per-frame ancillary packet buffer (top). Stores non-image packets in a slot
// ring, binds them to a frame on commit, replays them oldest first and then
// lets the image packet through. Tracks occupied, committed and pending counts.
// Assumes NUM_SLOTS >= MAX_PKTS >= 1, NUM_SLOTS >= 2, MAX_LEN >= 10, SYM_W >= 4.
module anc_pkt_buffer #(
    parameter  int SYM_W     = 8,
    parameter  int NUM_SLOTS = 8,
    parameter  int MAX_PKTS  = 4,
    parameter  int MAX_LEN   = 12,
    parameter  int CNT_W     = 8,
    localparam int SLOT_AW   = $clog2(NUM_SLOTS),
    localparam int SLOT_CW   = $clog2(NUM_SLOTS + 1),
    localparam int PKT_CW    = $clog2(MAX_PKTS + 1),
    localparam int IDX_W     = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SYM_W-1:0] in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic             ctrl_keep,
    input  logic             frame_commit,
    input  logic             frame_drop,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SYM_W-1:0] out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic [CNT_W-1:0] evict_count,
    output logic [CNT_W-1:0] trunc_count
);
    logic [SLOT_CW-1:0] used, cmt_cnt;
    logic [PKT_CW-1:0]  pend_live;
    logic               drop_img, evict, pass_vis, rep_ready;
    logic               wr_en, hdr_store, pkt_done, trunc_hit, pass_route, img_done;
    logic [SLOT_AW-1:0] wr_slot, kill_slot, rd_slot;
    logic [IDX_W-1:0]   wr_idx, rd_idx, rd_len;
    logic [SYM_W-1:0]   wr_data, rd_data, rep_data;
    logic               rep_valid, rep_sop, rep_eop, slot_free;

    anc_intake #(.SYM_W(SYM_W), .NUM_SLOTS(NUM_SLOTS), .MAX_LEN(MAX_LEN)) u_intake (
        .clk, .rst_n, .in_valid, .in_data, .in_sop, .in_eop, .in_ready, .ctrl_keep,
        .slot_avail (used < SLOT_CW'(NUM_SLOTS)),
        .replay_busy(cmt_cnt != '0),
        .drop_img, .out_ready, .wr_en, .wr_slot, .wr_idx, .wr_data,
        .hdr_store, .pkt_done, .trunc_hit, .pass_route, .img_done
    );

    anc_slot_store #(.SYM_W(SYM_W), .NUM_SLOTS(NUM_SLOTS), .MAX_LEN(MAX_LEN)) u_store (
        .clk, .rst_n, .wr_en, .wr_slot, .wr_idx, .wr_data,
        .kill_en(evict), .kill_slot, .rd_slot, .rd_idx, .rd_data, .rd_len
    );

    anc_replay #(.SYM_W(SYM_W), .NUM_SLOTS(NUM_SLOTS), .MAX_LEN(MAX_LEN)) u_replay (
        .clk, .rst_n, .active(cmt_cnt != '0), .rd_len, .rd_data, .rep_ready,
        .rd_slot, .rd_idx, .rep_valid, .rep_data, .rep_sop, .rep_eop, .slot_free
    );

    anc_sat_counter #(.W(CNT_W)) u_evict_cnt (.clk, .rst_n, .inc(evict),     .count(evict_count));
    anc_sat_counter #(.W(CNT_W)) u_trunc_cnt (.clk, .rst_n, .inc(trunc_hit), .count(trunc_count));

    // Eviction decision and the slot of the oldest live pending packet.
    always_comb begin
        int k;
        evict     = hdr_store && !frame_commit && (pend_live == PKT_CW'(MAX_PKTS));
        k         = (int'(wr_slot) + NUM_SLOTS - int'(pend_live)) % NUM_SLOTS;
        kill_slot = SLOT_AW'(k);
    end

    // Occupied, committed and live-pending slot counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used      <= '0;
            cmt_cnt   <= '0;
            pend_live <= '0;
        end else begin
            used      <= used + SLOT_CW'(pkt_done) - SLOT_CW'(slot_free);
            cmt_cnt   <= cmt_cnt - SLOT_CW'(slot_free) + (frame_commit ? used - cmt_cnt : '0);
            pend_live <= frame_commit ? PKT_CW'(pkt_done)
                                      : pend_live + PKT_CW'(pkt_done) - PKT_CW'(evict);
        end
    end

    // Marks the next image packet for silent discard after a drop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          drop_img <= 1'b0;
        else if (frame_drop) drop_img <= 1'b1;
        else if (img_done)   drop_img <= 1'b0;
    end

    // Output selects the passing image or the replayed packets.
    always_comb begin
        pass_vis  = pass_route && !drop_img;
        rep_ready = out_ready && !pass_vis;
        out_valid = pass_vis ? in_valid : rep_valid;
        out_data  = pass_vis ? in_data  : rep_data;
        out_sop   = pass_vis ? in_sop   : rep_sop;
        out_eop   = pass_vis ? in_eop   : rep_eop;
    end
endmodule

// File: rtl/anc_pkt_buffer_chk.sv
`timescale 1ns/1ps
// Assertion checker for anc_pkt_buffer, attached with bind below.
// Observes occupancy counters, replay handshake and status counters.
module anc_pkt_buffer_chk #(
    parameter  int SYM_W     = 8,
    parameter  int NUM_SLOTS = 8,
    parameter  int MAX_PKTS  = 4,
    parameter  int CNT_W     = 8,
    localparam int SLOT_CW   = $clog2(NUM_SLOTS + 1),
    localparam int PKT_CW    = $clog2(MAX_PKTS + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SLOT_CW-1:0] used,
    input logic [SLOT_CW-1:0] cmt_cnt,
    input logic [PKT_CW-1:0]  pend_live,
    input logic               rep_valid,
    input logic               rep_ready,
    input logic [SYM_W-1:0]   rep_data,
    input logic               rep_sop,
    input logic               rep_eop,
    input logic [CNT_W-1:0]   evict_count,
    input logic [CNT_W-1:0]   trunc_count
);
    // R9: occupancy never exceeds the ring
    p_ring_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        used <= SLOT_CW'(NUM_SLOTS));

    // R9: committed slots are a subset of occupied slots
    p_commit_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_cnt <= used);

    // R5: live pending packets never exceed the frame quota
    p_frame_quota_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_live <= PKT_CW'(MAX_PKTS));

    // R1: no replay output while nothing is committed
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_cnt == '0) |-> !rep_valid);

    // R11: a stalled replay symbol is held
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_data)
                                       && $stable(rep_sop) && $stable(rep_eop)));

    // R10: status counters never decrease
    p_evict_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evict_count >= $past(evict_count));
    p_trunc_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trunc_count >= $past(trunc_count));
endmodule

bind anc_pkt_buffer anc_pkt_buffer_chk #(
    .SYM_W(SYM_W), .NUM_SLOTS(NUM_SLOTS), .MAX_PKTS(MAX_PKTS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .used(used), .cmt_cnt(cmt_cnt), .pend_live(pend_live),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_data(rep_data),
    .rep_sop(rep_sop), .rep_eop(rep_eop),
    .evict_count(evict_count), .trunc_count(trunc_count)
);

// File: tb/anc_pkt_buffer_tb.sv
`timescale 1ns/1ps
// Directed bench for anc_pkt_buffer: one task per scenario, each self-checking.
module anc_pkt_buffer_tb;
    localparam int SYM_W = 8, NUM_SLOTS = 8, MAX_PKTS = 4, MAX_LEN = 12, CNT_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_ready;
    logic [SYM_W-1:0] in_data = '0;
    logic ctrl_keep = 1'b0, frame_commit = 1'b0, frame_drop = 1'b0, out_ready = 1'b1;
    logic out_valid, out_sop, out_eop;
    logic [SYM_W-1:0] out_data;
    logic [CNT_W-1:0] evict_count, trunc_count;

    int errors = 0, checks = 0, body_stalls = 0;
    int cap_d[$], cap_s[$], cap_e[$], exp_d[$], exp_s[$], exp_e[$];

    anc_pkt_buffer #(.SYM_W(SYM_W), .NUM_SLOTS(NUM_SLOTS), .MAX_PKTS(MAX_PKTS),
                     .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_dut (.*);

    always #10 clk = ~clk;  // 50 MHz

    // Capture output transfers mid-cycle.
    always begin
        @(negedge clk); #5;
        if (rst_n && out_valid && out_ready) begin
            cap_d.push_back(int'(out_data)); cap_s.push_back(int'(out_sop)); cap_e.push_back(int'(out_eop));
        end
    end

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: run hung (act=timeout exp=done)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic clear_streams();
        cap_d.delete(); cap_s.delete(); cap_e.delete();
        exp_d.delete(); exp_s.delete(); exp_e.delete();
    endtask

    // Expected replay of a stored packet (truncated to MAX_LEN when store=1).
    task automatic expect_pkt(input int typ, input int tag, input int len, input bit store);
        int n = (store && len > MAX_LEN) ? MAX_LEN : len;
        for (int i = 0; i < n; i++) begin
            exp_d.push_back(i == 0 ? (tag * 16 + typ) : (tag * 16 + (i & 15)));
            exp_s.push_back(i == 0); exp_e.push_back(i == n - 1);
        end
    endtask

    task automatic compare(input string req);
        bit ok = (cap_d.size() == exp_d.size());
        check(ok, {req, " length"}, cap_d.size(), exp_d.size());
        if (ok) begin
            for (int i = 0; i < exp_d.size(); i++)
                if (cap_d[i] != exp_d[i] || cap_s[i] != exp_s[i] || cap_e[i] != exp_e[i]) begin
                    check(1'b0, {req, " symbol"}, cap_d[i] * 4 + cap_s[i] * 2 + cap_e[i],
                          exp_d[i] * 4 + exp_s[i] * 2 + exp_e[i]);
                    break;
                end
        end
        clear_streams();
    endtask

    // Send one packet: header = {tag, type}, body i = {tag, i}.
    task automatic send_pkt(input int typ, input int tag, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == len - 1);
            in_data  = SYM_W'(i == 0 ? (tag * 16 + typ) : (tag * 16 + (i & 15)));
            #1;
            while (!in_ready) begin
                if (i != 0) body_stalls++;
                @(negedge clk); #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    endtask

    task automatic pulse_commit();
        @(negedge clk); frame_commit = 1'b1;
        @(negedge clk); frame_commit = 1'b0;
    endtask

    task automatic drain();
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        #5;
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(evict_count == 0 && trunc_count == 0, "R1 counters after reset",
              evict_count + trunc_count, 0);
    endtask

    task automatic t_order();
        send_pkt(1, 1, 3); send_pkt(2, 2, 5);
        drain();
        check(cap_d.size() == 0, "R2 nothing before commit", cap_d.size(), 0);
        pulse_commit(); drain();
        expect_pkt(1, 1, 3, 1); expect_pkt(2, 2, 5, 1);
        compare("R2 replay order");
        send_pkt(0, 3, 4); drain();
        expect_pkt(0, 3, 4, 0);
        compare("R8 image pass");
    endtask

    task automatic t_trunc();
        body_stalls = 0;
        send_pkt(1, 4, MAX_LEN + 3);
        check(body_stalls == 0, "R3 no stall on excess", body_stalls, 0);
        pulse_commit(); drain();
        expect_pkt(1, 4, MAX_LEN + 3, 1);
        compare("R3 truncated replay");
        check(trunc_count == 1, "R4 trunc count", trunc_count, 1);
    endtask

    task automatic t_evict();
        for (int t = 1; t <= 5; t++) send_pkt(1, t, 2);
        check(evict_count == 1, "R5 evict count", evict_count, 1);
        pulse_commit(); drain();
        for (int t = 2; t <= 5; t++) expect_pkt(1, t, 2, 1);
        compare("R5 oldest evicted");
    endtask

    task automatic t_drop();
        send_pkt(1, 6, 2); send_pkt(1, 7, 2);
        @(negedge clk); frame_drop = 1'b1;
        @(negedge clk); frame_drop = 1'b0;
        send_pkt(0, 8, 3); drain();
        check(cap_d.size() == 0, "R6 dropped image hidden", cap_d.size(), 0);
        send_pkt(1, 9, 2); send_pkt(1, 10, 2); send_pkt(1, 11, 2);
        check(evict_count == 2, "R6 carried packets count toward quota", evict_count, 2);
        pulse_commit(); drain();
        expect_pkt(1, 7, 2, 1); expect_pkt(1, 9, 2, 1);
        expect_pkt(1, 10, 2, 1); expect_pkt(1, 11, 2, 1);
        compare("R6 carried replay");
    endtask

    task automatic t_ctrl();
        ctrl_keep = 1'b0;
        send_pkt(15, 12, 10); send_pkt(3, 13, 2);
        pulse_commit(); drain();
        expect_pkt(3, 13, 2, 1);
        compare("R7 control consumed");
        ctrl_keep = 1'b1;
        send_pkt(15, 14, 10);
        pulse_commit(); drain();
        expect_pkt(15, 14, 10, 1);
        compare("R7 control stored");
        ctrl_keep = 1'b0;
    endtask

    task automatic t_stall_image();
        int held;
        out_ready = 1'b0;
        send_pkt(4, 5, 3);
        pulse_commit();
        fork
            send_pkt(0, 3, 4);
            begin
                repeat (2) @(negedge clk); #6;
                held = int'(out_data);
                check(in_ready == 1'b0, "R8 image held behind replay", in_ready, 0);
                @(negedge clk); #6;
                check(out_valid == 1'b1 && int'(out_data) == held && out_sop == 1'b1,
                      "R11 stalled symbol held", int'(out_data), 5 * 16 + 4);
                @(negedge clk); out_ready = 1'b1;
            end
        join
        drain();
        expect_pkt(4, 5, 3, 1); expect_pkt(0, 3, 4, 0);
        compare("R8 replay then image");
    endtask

    task automatic t_capacity();
        out_ready = 1'b0;
        for (int t = 1; t <= 4; t++) send_pkt(2, t, 2);
        pulse_commit();
        for (int t = 5; t <= 8; t++) send_pkt(2, t, 2);
        fork
            send_pkt(2, 9, 2);
            begin
                repeat (3) @(negedge clk); #6;
                check(in_ready == 1'b0, "R9 header held when ring full", in_ready, 0);
                @(negedge clk); out_ready = 1'b1;
            end
        join
        check(evict_count == 3, "R5 evict on freed slot", evict_count, 3);
        pulse_commit(); drain();
        for (int t = 1; t <= 4; t++) expect_pkt(2, t, 2, 1);
        for (int t = 6; t <= 9; t++) expect_pkt(2, t, 2, 1);
        compare("R9 ring reuse");
    endtask

    task automatic t_saturate();
        for (int t = 0; t < 6; t++) begin
            send_pkt(1, t, MAX_LEN + 1);
            if (t % 3 == 2) begin pulse_commit(); drain(); end
        end
        check(trunc_count == 7, "R10 trunc reaches top", trunc_count, 7);
        for (int t = 6; t < 8; t++) send_pkt(1, t, MAX_LEN + 1);
        pulse_commit(); drain();
        check(trunc_count == 7, "R10 trunc saturates", trunc_count, 7);
        check(evict_count == 3, "R10 evict unchanged", evict_count, 3);
        clear_streams();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_trunc();
        t_evict();
        t_drop();
        t_ctrl();
        t_stall_image();
        t_capacity();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule